// File: doc/BRIEF.md
# Barrel Shifter Operand Generator

This block forms the second operand of a 32-bit data-processing instruction and the carry that the shift produces. It takes the low twelve bits of the instruction word, a selector that picks between the rotated 8-bit immediate form and the shifted-register form, the Rm value, the low byte of Rs, two flags that mark Rm or Rs as the program counter, and the current carry flag. It returns the operand, the shifter carry-out and a flag that tells the sequencer the instruction needs one extra cycle.

All of the architecture's awkward encodings are resolved here. These are an immediate amount of zero that stands for a shift by 32 or for a rotate through carry, register amounts of 32 and above, and a register rotate by a multiple of 32. The ALU then sees a plain operand and a plain carry. The block is purely combinational. It has no handshake because it sits inside the execute stage and every output is valid in the same cycle as its inputs.

Top module: `bs_operand_gen`

## Requirements
- R1: When `imm_sel_i` is 1 the operand comes from the rotated-immediate path. Otherwise it comes from the shifted-register path, and `insn_i[4]`=1 selects a register-specified amount. `extra_cycle_o` is 1 exactly when `imm_sel_i` is 0 and `insn_i[4]` is 1.
- R2: In register-amount form the amount is `amt_reg_i`. That amount is increased by 4 (modulo 256) when `rs_is_pc_i` is set, and Rm is increased by 4 when `rm_is_pc_i` is set. A resulting amount of 0 passes Rm unchanged, and the carry-out equals `carry_i`.
- R3: A register amount of exactly 32 gives operand 0 for both left and right logical shifts. The carry is Rm bit 0 for the left shift and Rm bit 31 for the right shift. Amounts above 32 give operand 0 and carry 0 for both.
- R4: An arithmetic right shift by a register amount of 32 or more fills every bit with Rm bit 31, and the carry is also Rm bit 31.
- R5: A register rotate rotates right by `amount[4:0]`, with carry equal to the last bit rotated out. When the amount is non-zero but its low five bits are zero, Rm is unchanged and the carry is Rm bit 31.
- R6: An immediate amount of zero has a different meaning for each shift kind. For a left shift Rm passes through and the carry equals `carry_i`. Logical and arithmetic right shifts act as a shift by 32. A rotate becomes a rotate-through-carry: `carry_i` moves into bit 31 and Rm bit 0 becomes the carry.
- R7: The shift kind is `insn_i[6:5]`: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. In immediate form (`insn_i[4]`=0) the amount is `insn_i[11:7]`. For amounts 1 to 31 the carry is bit 32−n of Rm for the left shift and bit n−1 for the other kinds.
- R8: The rotated immediate is `insn_i[7:0]` rotated right by twice `insn_i[11:8]`. Its carry is `carry_i` when `insn_i[11:8]` is 0, and bit 31 of the result otherwise.
- R9: Register amounts from 1 to 31 shift normally, and the carry is the last bit shifted out.
- R10: In immediate-amount form the program-counter flags have no effect, and Rm is used unadjusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_sel_i | input | 1 | 1 selects the rotated 8-bit immediate operand |
| insn_i | input | 12 | Low twelve bits of the instruction word |
| rm_val_i | input | 32 | Value read from the Rm register |
| amt_reg_i | input | 8 | Low byte of the Rs register |
| rm_is_pc_i | input | 1 | Rm is the program counter |
| rs_is_pc_i | input | 1 | Rs is the program counter |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifted or rotated second operand |
| carry_o | output | 1 | Shifter carry-out |
| extra_cycle_o | output | 1 | Register-specified shift needs one more cycle |

## Verification
Assertions check the following relations wherever the inputs allow them:
- A zero register amount passes Rm and `carry_i` through.
- A large arithmetic shift fills the operand with copies of the carry.
- Oversized logical shifts give zero.
- A zero rotation on the immediate path returns the raw byte and the incoming carry.
- The extra-cycle flag is never set on the immediate path.

The exact result and carry of every other amount, the rotate-through-carry and shift-by-32 encodings of an immediate zero, and the use of the unadjusted Rm in immediate form are shown only by the bench. It compares random and directed vectors against its own 64-bit reference.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/bs_amount_sel.sv
// Picks the shift source value and amount; folds the immediate-zero encodings
// into an amount of 32 or a rotate-through-carry request.
module bs_amount_sel
  import bsg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int PC_ADJ = 4
) (
  input  logic              reg_form_i,
  input  logic [4:0]        imm_amt_i,
  input  shift_kind_e       kind_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [AMT_W-1:0]  amt_reg_i,
  input  logic              rm_is_pc_i,
  input  logic              rs_is_pc_i,
  output logic [DATA_W-1:0] val_o,
  output logic [AMT_W-1:0]  amt_o,
  output logic              rrx_o
);
  localparam logic [DATA_W-1:0] RM_ADJ  = DATA_W'(PC_ADJ);
  localparam logic [AMT_W-1:0]  AMT_ADJ = AMT_W'(PC_ADJ);
  localparam logic [AMT_W-1:0]  FULL    = AMT_W'(DATA_W);

  always_comb begin
    val_o = rm_val_i;
    amt_o = '0;
    rrx_o = 1'b0;
    if (reg_form_i) begin
      val_o = rm_val_i + (rm_is_pc_i ? RM_ADJ : '0);
      amt_o = amt_reg_i + (rs_is_pc_i ? AMT_ADJ : '0);
    end else if (imm_amt_i == 5'd0) begin
      unique case (kind_i)
        SH_LSR, SH_ASR: amt_o = FULL;
        SH_ROR:         rrx_o = 1'b1;
        default:        amt_o = '0;
      endcase
    end else begin
      amt_o = AMT_W'(imm_amt_i);
    end
  end
endmodule

// File: rtl/bs_shift_core.sv
// Four-kind shifter with defined results for zero and oversized amounts.
module bs_shift_core
  import bsg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  input  logic              rrx_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [IDX_W-1:0] sh;
  logic [IDX_W-1:0] neg_sh;
  logic [IDX_W-1:0] last_out;
  logic             msb;

  assign sh       = amt_i[IDX_W-1:0];
  assign neg_sh   = IDX_W'(0) - sh;
  assign last_out = sh - IDX_W'(1);
  assign msb      = val_i[DATA_W-1];

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (rrx_i) begin
      res_o   = {carry_i, val_i[DATA_W-1:1]};
      carry_o = val_i[0];
    end else if (amt_i != '0) begin
      unique case (kind_i)
        SH_LSL: begin
          if (amt_i < FULL) begin
            res_o   = val_i << sh;
            carry_o = val_i[neg_sh];
          end else begin
            res_o   = '0;
            carry_o = (amt_i == FULL) ? val_i[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (amt_i < FULL) begin
            res_o   = val_i >> sh;
            carry_o = val_i[last_out];
          end else begin
            res_o   = '0;
            carry_o = (amt_i == FULL) ? msb : 1'b0;
          end
        end
        SH_ASR: begin
          if (amt_i < FULL) begin
            res_o   = DATA_W'($signed(val_i) >>> sh);
            carry_o = val_i[last_out];
          end else begin
            res_o   = {DATA_W{msb}};
            carry_o = msb;
          end
        end
        default: begin
          if (sh != '0) begin
            res_o   = (val_i >> sh) | (val_i << neg_sh);
            carry_o = val_i[last_out];
          end else begin
            res_o   = val_i;
            carry_o = msb;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bs_rot_imm.sv
// Rotated 8-bit immediate operand path.
module bs_rot_imm #(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        imm8_i,
  input  logic [3:0]        rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] ext;
  logic [IDX_W-1:0]  r;

  assign ext = DATA_W'(imm8_i);
  assign r   = IDX_W'({rot_i, 1'b0});

  always_comb begin
    if (rot_i == 4'd0) begin
      res_o   = ext;
      carry_o = carry_i;
    end else begin
      res_o   = (ext >> r) | (ext << (IDX_W'(0) - r));
      carry_o = res_o[DATA_W-1];
    end
  end
endmodule

// File: rtl/bs_operand_gen.sv
module bs_operand_gen
  import bsg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int PC_ADJ = 4
) (
  input  logic              imm_sel_i,
  input  logic [11:0]       insn_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [AMT_W-1:0]  amt_reg_i,
  input  logic              rm_is_pc_i,
  input  logic              rs_is_pc_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o,
  output logic              extra_cycle_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  shift_kind_e       kind;
  logic              reg_form;
  logic [DATA_W-1:0] sh_val;
  logic [AMT_W-1:0]  sh_amt;
  logic              sh_rrx;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cy;
  logic [DATA_W-1:0] ri_res;
  logic              ri_cy;

  assign kind     = shift_kind_e'(insn_i[6:5]);
  assign reg_form = insn_i[4];

  bs_amount_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W), .PC_ADJ(PC_ADJ)) u_amt (
    .reg_form_i (reg_form),
    .imm_amt_i  (insn_i[11:7]),
    .kind_i     (kind),
    .rm_val_i   (rm_val_i),
    .amt_reg_i  (amt_reg_i),
    .rm_is_pc_i (rm_is_pc_i),
    .rs_is_pc_i (rs_is_pc_i),
    .val_o      (sh_val),
    .amt_o      (sh_amt),
    .rrx_o      (sh_rrx)
  );

  bs_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .val_i   (sh_val),
    .amt_i   (sh_amt),
    .kind_i  (kind),
    .rrx_i   (sh_rrx),
    .carry_i (carry_i),
    .res_o   (sh_res),
    .carry_o (sh_cy)
  );

  bs_rot_imm #(.DATA_W(DATA_W)) u_rimm (
    .imm8_i  (insn_i[7:0]),
    .rot_i   (insn_i[11:8]),
    .carry_i (carry_i),
    .res_o   (ri_res),
    .carry_o (ri_cy)
  );

  assign operand_o     = imm_sel_i ? ri_res : sh_res;
  assign carry_o       = imm_sel_i ? ri_cy  : sh_cy;
  assign extra_cycle_o = !imm_sel_i && reg_form;

  // Port-level checks across the three sub-blocks
  logic [AMT_W-1:0]  chk_amt;
  logic [DATA_W-1:0] chk_rm;
  logic              chk_reg;
  assign chk_amt = amt_reg_i + (rs_is_pc_i ? AMT_W'(PC_ADJ) : '0);
  assign chk_rm  = rm_val_i + (rm_is_pc_i ? DATA_W'(PC_ADJ) : '0);
  assign chk_reg = !imm_sel_i && reg_form;

  always_comb begin
    AST_IMM_NO_EXTRA: assert (!(imm_sel_i && extra_cycle_o)) else $error("extra cycle on immediate path"); // R1
    if (chk_reg && chk_amt == '0) begin
      AST_ZERO_AMT_PASS: assert (operand_o == chk_rm && carry_o == carry_i) else $error("zero amount not passed"); // R2
    end
    if (chk_reg && chk_amt > FULL && (kind == SH_LSL || kind == SH_LSR)) begin
      AST_LARGE_LOGIC_ZERO: assert (operand_o == '0 && !carry_o) else $error("oversized logical shift"); // R3
    end
    if (chk_reg && chk_amt >= FULL && kind == SH_ASR) begin
      AST_ASR_SIGN_FILL: assert (operand_o == {DATA_W{carry_o}}) else $error("asr fill"); // R4
    end
    if (imm_sel_i && insn_i[11:8] == 4'd0) begin
      AST_ROTIMM_RAW: assert (operand_o == DATA_W'(insn_i[7:0]) && carry_o == carry_i) else $error("rot imm zero"); // R8
    end
  end
endmodule

// File: tb/bs_operand_gen_bench.sv
module bs_operand_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        imm_sel;
  logic [11:0] insn;
  logic [31:0] rm_val;
  logic [7:0]  amt_reg;
  logic        rm_pc, rs_pc, cin;
  logic [31:0] operand;
  logic        cout, xcyc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  bs_operand_gen u_bs_operand_gen (
    .imm_sel_i(imm_sel), .insn_i(insn), .rm_val_i(rm_val), .amt_reg_i(amt_reg),
    .rm_is_pc_i(rm_pc), .rs_is_pc_i(rs_pc), .carry_i(cin),
    .operand_o(operand), .carry_o(cout), .extra_cycle_o(xcyc)
  );

  // Reference: result in [31:0], carry in [32]
  function automatic logic [32:0] shift_ref(input logic [1:0] k, input logic [31:0] v,
                                            input int a, input logic c, input logic rrx);
    logic [64:0] w;
    logic [32:0] x;
    logic [63:0] dbl;
    int r;
    if (rrx) return {v[0], c, v[31:1]};
    if (a == 0) return {c, v};
    case (k)
      2'b00: begin
        if (a > 32) return 33'd0;
        w = {33'd0, v} << a;
        return {w[32], w[31:0]};
      end
      2'b01: begin
        if (a > 32) return 33'd0;
        x = {v, 1'b0} >> a;
        return {x[0], x[32:1]};
      end
      2'b10: begin
        x = $signed({v, 1'b0}) >>> ((a > 32) ? 32 : a);
        return {x[0], x[32:1]};
      end
      default: begin
        r = a % 32;
        if (r == 0) return {v[31], v};
        dbl = {v, v} >> r;
        return {dbl[31], dbl[31:0]};
      end
    endcase
  endfunction

  function automatic logic [32:0] model(input logic isel, input logic [11:0] ins,
      input logic [31:0] rm, input logic [7:0] rs, input logic rmp, input logic rsp, input logic c);
    logic [63:0] dbl;
    logic [31:0] ri;
    logic [7:0] a8;
    int n;
    if (isel) begin
      n = 2 * int'(ins[11:8]);
      dbl = {24'd0, ins[7:0], 24'd0, ins[7:0]} >> n;
      ri = dbl[31:0];
      return {(n == 0) ? c : ri[31], ri};
    end
    if (ins[4]) begin
      a8 = rs + (rsp ? 8'd4 : 8'd0);
      return shift_ref(ins[6:5], rm + (rmp ? 32'd4 : 32'd0), int'(a8), c, 1'b0);
    end
    n = int'(ins[11:7]);
    if (n == 0 && ins[6:5] == 2'b11) return shift_ref(2'b11, rm, 0, c, 1'b1);
    if (n == 0 && (ins[6:5] == 2'b01 || ins[6:5] == 2'b10)) return shift_ref(ins[6:5], rm, 32, c, 1'b0);
    return shift_ref(ins[6:5], rm, n, c, 1'b0);
  endfunction

  function automatic string tag_of(input logic isel, input logic [11:0] ins,
                                   input logic [7:0] rs, input logic rmp, input logic rsp);
    logic [7:0] a8;
    if (isel) return "R8";
    if (ins[4]) begin
      a8 = rs + (rsp ? 8'd4 : 8'd0);
      if (a8 == 0) return "R2";
      if (ins[6:5] == 2'b11) return "R5";
      if (ins[6:5] == 2'b10 && a8 >= 32) return "R4";
      if (a8 >= 32) return "R3";
      return "R9";
    end
    if (ins[11:7] == 0) return "R6";
    if (rmp) return "R10";
    return "R7";
  endfunction

  task automatic apply(input logic isel, input logic [11:0] ins, input logic [31:0] rm,
                       input logic [7:0] rs, input logic rmp, input logic rsp, input logic c);
    logic [32:0] exp;
    string t;
    @(posedge clk);
    imm_sel = isel; insn = ins; rm_val = rm; amt_reg = rs; rm_pc = rmp; rs_pc = rsp; cin = c;
    @(negedge clk);
    exp = model(isel, ins, rm, rs, rmp, rsp, c);
    t = tag_of(isel, ins, rs, rmp, rsp);
    checks++;
    if ({cout, operand} !== exp) begin
      errors++;
      $display("FAIL %s: actual carry=%0b op=%08h expected carry=%0b op=%08h",
               t, cout, operand, exp[32], exp[31:0]);
    end
    checks++;
    if (xcyc !== (!isel && ins[4])) begin
      errors++;
      $display("FAIL R1: extra_cycle actual=%0b expected=%0b", xcyc, (!isel && ins[4]));
    end
  endtask

  function automatic logic [11:0] reg_ins(input logic [1:0] k);
    return {4'h7, 1'b0, k, 1'b1, 4'h3};
  endfunction
  function automatic logic [11:0] imm_ins(input logic [4:0] n, input logic [1:0] k);
    return {n, k, 1'b0, 4'h2};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] ri;
    logic [7:0] rr;
    imm_sel = 0; insn = 0; rm_val = 0; amt_reg = 0; rm_pc = 0; rs_pc = 0; cin = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // quiescent inputs: immediate LSL #0 of zero (R6)
    apply(0, 12'h000, 32'h0, 8'h0, 0, 0, 1'b0);
    // R3 boundaries
    apply(0, reg_ins(2'b00), 32'h8000_0001, 8'd32, 0, 0, 0);
    apply(0, reg_ins(2'b00), 32'hFFFF_FFFF, 8'd33, 0, 0, 1);
    apply(0, reg_ins(2'b01), 32'h8000_0000, 8'd32, 0, 0, 0);
    apply(0, reg_ins(2'b01), 32'hFFFF_FFFF, 8'd200, 0, 0, 1);
    // R4
    apply(0, reg_ins(2'b10), 32'h9000_0000, 8'd40, 0, 0, 0);
    apply(0, reg_ins(2'b10), 32'h7000_0000, 8'd32, 0, 0, 1);
    // R5
    apply(0, reg_ins(2'b11), 32'h8000_0001, 8'd32, 0, 0, 0);
    apply(0, reg_ins(2'b11), 32'h0000_00F1, 8'd36, 0, 0, 0);
    // R2: zero amount, PC adjust on both operands
    apply(0, reg_ins(2'b01), 32'h1234_5678, 8'd0, 0, 0, 1);
    apply(0, reg_ins(2'b00), 32'h0000_0100, 8'd252, 1, 1, 0);
    apply(0, reg_ins(2'b00), 32'h0000_0100, 8'd1, 1, 0, 0);
    // R6 immediate zero encodings
    apply(0, imm_ins(5'd0, 2'b01), 32'h8000_0000, 8'd0, 0, 0, 0);
    apply(0, imm_ins(5'd0, 2'b10), 32'h8000_0000, 8'd0, 0, 0, 0);
    apply(0, imm_ins(5'd0, 2'b11), 32'h0000_0003, 8'd0, 0, 0, 1);
    apply(0, imm_ins(5'd0, 2'b00), 32'hDEAD_BEEF, 8'd0, 0, 0, 1);
    // R7 and R10
    apply(0, imm_ins(5'd31, 2'b00), 32'h0000_0002, 8'd0, 0, 0, 0);
    apply(0, imm_ins(5'd1, 2'b10), 32'h8000_0001, 8'd0, 1, 1, 0);
    // R8
    apply(1, 12'h0A5, 32'h0, 8'd0, 0, 0, 1);
    apply(1, 12'h103, 32'h0, 8'd0, 0, 0, 0);
    apply(1, 12'hFFF, 32'h0, 8'd0, 0, 0, 0);
    // constrained random
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1500; i++) begin
      ri = 12'($urandom());
      case ($urandom() % 6)
        0: rr = 8'd0;
        1: rr = 8'd32;
        2: rr = 8'd28 + 8'($urandom() % 8);
        default: rr = 8'($urandom());
      endcase
      apply(($urandom() % 4) == 0, ri, $urandom(), rr,
            ($urandom() % 4) == 0, ($urandom() % 4) == 0, 1'($urandom()));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule